// File: doc/BRIEF.md
# Multi-channel timer unit

This block gathers two or three countdown timer channels behind one 4 KB register window on a simple single-cycle request bus. Besides the per-channel registers it holds a shared run register, with one bit per channel that lets that channel count, and an optional output-control register. A decoder splits the window into per-channel windows, and every channel drives its own interrupt line.

Each channel counts down on ticks taken from a shared free-running prescaler. When a tick finds the count at zero, the channel reloads from its reload register and sets an underflow flag. The interrupt line is the flag gated by an enable bit. Two parameters decide whether the third channel exists and whether the output-control register exists. The third channel also carries a plain capture register. Any access to an offset that maps to nothing, and any write of a value the unit cannot honour, is answered with a one-cycle error pulse.

Top module: `tmr_unit`

## Requirements
- R1: After reset the run register reads 0, so all channels are stopped. Every reload and count register reads 0xFFFFFFFF. Every control, capture and output-control register reads 0. `err`, `rsp_valid` and `irq` are 0.
- R2: Map by byte offset: 0x00 output control, 0x04 run register. Channel 0 has reload, count and control at 0x08, 0x0C and 0x10. Channel 1 has them at 0x14, 0x18 and 0x1C. Channel 2 has them at 0x20, 0x24 and 0x28, with its capture register at 0x2C. A request sampled at edge T gives `rsp_valid` and `rsp_rdata` after edge T.
- R3: An access is invalid if its offset is not word aligned, is 0x30 or above, is 0x20 or above without the third channel, or is 0x00 without the output-control register. An invalid access gives `err`=1 in the response cycle and `rsp_rdata`=0, and it changes no register.
- R4: Bit i of the run register (bits 2:0) lets channel i count when 1. A channel whose bit is 0 holds its count.
- R5: Without the third channel, a run-register write with bit 2 set raises `err`. Bit 2 then reads 0, and bits 1:0 are still taken from the write.
- R6: A running channel decrements its count on each selected tick. A tick that finds the count at 0 loads the reload value instead and sets the underflow flag (control bit 8).
- R7: Control bits 2:0 pick the tick rate: value s gives one tick every 4^s clocks, for s from 0 to 4. A control write with a value of 5 to 7 there raises `err` and leaves the whole control register unchanged.
- R8: `irq[i]` equals (underflow flag AND control bit 5) of channel i, one clock later. Without the third channel `irq[2]` stays 0.
- R9: Writing 0 to control bit 8 clears the flag, and writing 1 leaves it as it is. An underflow on the same edge as a clearing write leaves the flag set.
- R10: A count-register write on the same edge as a tick stores the written value, and no decrement is applied on that edge.
- R11: The third channel's capture register reads back the value last written to it.
- R12: When present, the output-control register reads back the low OC_W bits of the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset within the window |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | DW | Read data (0 for writes and invalid accesses) |
| err | output | 1 | One-cycle error pulse in the response cycle |
| irq | output | 3 | Interrupt line per channel |

## Verification
Two pairs of events can land on one clock edge. The first pair is a channel underflow and a software write that clears the flag. The second is a tick and a software write to the count register. The bench lines up the first pair by parking a channel at count 0, starting it, and issuing the clearing control write on the very next edge, which is the underflow edge. It judges the outcome by reading the control register back, where the flag must still be set, and by reading the count one reload step later. For the second pair it writes the count while the channel runs at full rate and stops the channel one edge later. It then expects exactly the written value minus one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_OUTCTL, TGT_START, TGT_CH0, TGT_CH1, TGT_CH2
  } tgt_e;

  typedef struct packed {
    tgt_e       tgt;
    logic [1:0] reg_idx;
  } dec_t;

  // local register index inside a channel window
  localparam logic [1:0] LR_RELOAD = 2'd0;
  localparam logic [1:0] LR_COUNT  = 2'd1;
  localparam logic [1:0] LR_CTRL   = 2'd2;
  localparam logic [1:0] LR_CAPT   = 2'd3;

  // control register field positions
  localparam int SEL_W         = 3;
  localparam int CTRL_IE_BIT   = 5;
  localparam int CTRL_FLAG_BIT = 8;

  localparam int MAX_CH = 3;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int NSEL = 5
) (
  input  logic            clk,
  input  logic            rst,
  output logic [NSEL-1:0] tick
);
  localparam int PRE_W = 2 * (NSEL - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst) pre_q <= '0;
    else     pre_q <= pre_q + 1'b1;
  end

  // rate s fires once per 4^s clocks
  for (genvar s = 0; s < NSEL; s++) begin : g_rate
    if (s == 0) begin : g_full
      assign tick[s] = 1'b1;
    end else begin : g_div
      assign tick[s] = &pre_q[2*s-1:0];
    end
  end
endmodule

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode import tmr_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec
);
  localparam int WW = ADDR_W - 2;

  logic [WW-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    dec.tgt     = TGT_NONE;
    dec.reg_idx = 2'd0;
    if (addr[1:0] == 2'b00) begin
      if (word == WW'(0)) begin
        if (HAS_OUTCTL) dec.tgt = TGT_OUTCTL;
      end else if (word == WW'(1)) begin
        dec.tgt = TGT_START;
      end else if (word >= WW'(2) && word <= WW'(4)) begin
        dec.tgt     = TGT_CH0;
        dec.reg_idx = 2'(word - WW'(2));
      end else if (word >= WW'(5) && word <= WW'(7)) begin
        dec.tgt     = TGT_CH1;
        dec.reg_idx = 2'(word - WW'(5));
      end else if (word >= WW'(8) && word <= WW'(11)) begin
        // third window: byte offset minus 0x20 gives the local word
        if (HAS_CH2) begin
          dec.tgt     = TGT_CH2;
          dec.reg_idx = 2'(word - WW'(8));
        end
      end
    end
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel import tmr_pkg::*; #(
  parameter int DW       = 32,
  parameter int NSEL     = 5,
  parameter bit HAS_CAPT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [NSEL-1:0] tick,
  input  logic            wr_en,
  input  logic [1:0]      reg_idx,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            sel_bad,
  output logic            irq
);
  localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NSEL - 1);

  logic [DW-1:0]    reload_q, count_q, capt_rd, ctrl_view;
  logic [SEL_W-1:0] sel_q;
  logic             ie_q, flag_q;
  logic             tick_sel, step, underflow;
  logic             wr_reload, wr_count, wr_ctrl;

  always_comb begin
    tick_sel = 1'b0;
    for (int s = 0; s < NSEL; s++) begin
      if (sel_q == SEL_W'(s)) tick_sel = tick[s];
    end
  end

  assign step      = run && tick_sel;
  assign sel_bad   = wr_en && (reg_idx == LR_CTRL) && (wdata[SEL_W-1:0] > SEL_MAX);
  assign wr_reload = wr_en && (reg_idx == LR_RELOAD);
  assign wr_count  = wr_en && (reg_idx == LR_COUNT);
  assign wr_ctrl   = wr_en && (reg_idx == LR_CTRL) && !sel_bad;
  assign underflow = step && (count_q == '0) && !wr_count;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= wdata;
      if (wr_count)  count_q  <= wdata;
      else if (step) count_q  <= (count_q == '0) ? reload_q : count_q - 1'b1;
      if (wr_ctrl) begin
        sel_q <= wdata[SEL_W-1:0];
        ie_q  <= wdata[CTRL_IE_BIT];
      end
      // underflow has priority over a clearing write
      if (underflow)                             flag_q <= 1'b1;
      else if (wr_ctrl && !wdata[CTRL_FLAG_BIT]) flag_q <= 1'b0;
      irq <= flag_q & ie_q;
    end
  end

  if (HAS_CAPT) begin : g_capt
    logic [DW-1:0] capt_q;
    always_ff @(posedge clk) begin
      if (rst)                                capt_q <= '0;
      else if (wr_en && reg_idx == LR_CAPT)   capt_q <= wdata;
    end
    assign capt_rd = capt_q;
  end else begin : g_nocapt
    assign capt_rd = '0;
  end

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[SEL_W-1:0]     = sel_q;
    ctrl_view[CTRL_IE_BIT]   = ie_q;
    ctrl_view[CTRL_FLAG_BIT] = flag_q;
  end

  always_comb begin
    case (reg_idx)
      LR_RELOAD: rdata = reload_q;
      LR_COUNT:  rdata = count_q;
      LR_CTRL:   rdata = ctrl_view;
      default:   rdata = capt_rd;
    endcase
  end
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit import tmr_pkg::*; #(
  parameter int ADDR_W     = 12,
  parameter int DW         = 32,
  parameter bit HAS_CH2    = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1,
  parameter int OC_W       = 8,
  parameter int NSEL       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic              err,
  output logic [2:0]        irq
);
  localparam int NCH = HAS_CH2 ? 3 : 2;

  dec_t                        dec;
  logic [NSEL-1:0]             tick;
  logic [MAX_CH-1:0]           start_q, ch_hit, ch_wr, ch_bad, ch_irq;
  logic [MAX_CH-1:0][DW-1:0]   ch_rdata;
  logic [OC_W-1:0]             outctl_q;
  logic                        start_wr, start_bad, oc_wr, rd_ok, err_d;
  logic [DW-1:0]               rd_mux;

  tmr_addr_decode #(.ADDR_W(ADDR_W), .HAS_CH2(HAS_CH2), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .addr (req_addr),
    .dec  (dec)
  );

  tmr_prescaler #(.NSEL(NSEL)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  assign ch_hit[0] = (dec.tgt == TGT_CH0);
  assign ch_hit[1] = (dec.tgt == TGT_CH1);
  assign ch_hit[2] = (dec.tgt == TGT_CH2);
  assign ch_wr     = ch_hit & {MAX_CH{req_valid && req_write}};

  for (genvar c = 0; c < MAX_CH; c++) begin : g_ch
    if (c < NCH) begin : g_on
      tmr_channel #(.DW(DW), .NSEL(NSEL), .HAS_CAPT(c == 2)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .run     (start_q[c]),
        .tick    (tick),
        .wr_en   (ch_wr[c]),
        .reg_idx (dec.reg_idx),
        .wdata   (req_wdata),
        .rdata   (ch_rdata[c]),
        .sel_bad (ch_bad[c]),
        .irq     (ch_irq[c])
      );
    end else begin : g_off
      assign ch_rdata[c] = '0;
      assign ch_bad[c]   = 1'b0;
      assign ch_irq[c]   = 1'b0;
    end
  end

  assign start_wr  = req_valid && req_write && (dec.tgt == TGT_START);
  assign start_bad = start_wr && !HAS_CH2 && req_wdata[2];
  assign oc_wr     = req_valid && req_write && (dec.tgt == TGT_OUTCTL);
  assign rd_ok     = req_valid && !req_write && (dec.tgt != TGT_NONE);
  assign err_d     = req_valid && ((dec.tgt == TGT_NONE) || start_bad || (|ch_bad));

  always_comb begin
    case (dec.tgt)
      TGT_OUTCTL: rd_mux = {{(DW-OC_W){1'b0}}, outctl_q};
      TGT_START:  rd_mux = {{(DW-MAX_CH){1'b0}}, start_q};
      TGT_CH0:    rd_mux = ch_rdata[0];
      TGT_CH1:    rd_mux = ch_rdata[1];
      TGT_CH2:    rd_mux = ch_rdata[2];
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q   <= '0;
      outctl_q  <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      err       <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      err       <= err_d;
      rsp_rdata <= rd_ok ? rd_mux : '0;
      if (start_wr) start_q  <= {HAS_CH2 ? req_wdata[2] : 1'b0, req_wdata[1:0]};
      if (oc_wr)    outctl_q <= req_wdata[OC_W-1:0];
    end
  end

  assign irq = ch_irq;
endmodule

// File: rtl/tmr_unit_chk.sv
module tmr_unit_chk #(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter bit HAS_CH2 = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-3:0] req_word,
  input logic              start_bit2,
  input logic              rsp_valid,
  input logic [DW-1:0]     rsp_rdata,
  input logic              err,
  input logic [2:0]        irq
);
  localparam int WW = ADDR_W - 2;

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_HIGH_ADDR_ERR: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_word >= WW'(12)) |=> err); // R3

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    err |-> (rsp_rdata == '0)); // R3

  AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(req_valid)); // R3

  AST_MISSING_CH_START: assert property (@(posedge clk) disable iff (rst)
    (!HAS_CH2 && req_valid && req_write && req_word == WW'(1) && start_bit2) |=> err); // R5

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!err && !rsp_valid && irq == 3'b000)); // R1
endmodule

bind tmr_unit tmr_unit_chk #(.ADDR_W(ADDR_W), .DW(DW), .HAS_CH2(HAS_CH2)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_word   (req_addr[ADDR_W-1:2]),
  .start_bit2 (req_wdata[2]),
  .rsp_valid  (rsp_valid),
  .rsp_rdata  (rsp_rdata),
  .err        (err),
  .irq        (irq)
);

// File: tb/tmr_unit_test.sv
module tmr_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rv_a, er_a, rv_b, er_b;
  logic [31:0] rd_a, rd_b;
  logic [2:0]  irq_a, irq_b;

  int n_tests = 0, n_fail = 0;
  bit done = 0;
  logic [31:0] got_a, got_b;
  logic        gerr_a, gerr_b;

  always #5 clk = ~clk;

  // full configuration
  tmr_unit #(.HAS_CH2(1'b1), .HAS_OUTCTL(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_a),
    .rsp_rdata(rd_a), .err(er_a), .irq(irq_a));

  // reduced configuration on the same bus
  tmr_unit #(.HAS_CH2(1'b0), .HAS_OUTCTL(1'b0)) uut_lite (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rv_b),
    .rsp_rdata(rd_b), .err(er_b), .irq(irq_b));

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
    end
  endtask

  // one bus access = one clock edge; responses sampled 1 ns after it
  task automatic bus(input logic w, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    got_a = rd_a; gerr_a = er_a; got_b = rd_b; gerr_b = er_b;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // enables channels in mask for exactly e counting edges
  task automatic run_edges(input logic [2:0] mask, input int e);
    bus(1'b1, 12'h004, {29'd0, mask});
    if (e > 1) idle(e - 1);
    bus(1'b1, 12'h004, 32'd0);
  endtask

  function automatic bit valid_word(input bit full, input int w);
    if (w == 0) return full;
    if (w >= 1 && w <= 7) return 1'b1;
    if (w >= 8 && w <= 11) return full;
    return 1'b0;
  endfunction

  function automatic logic [31:0] reset_val(input int w);
    if (w == 2 || w == 3 || w == 5 || w == 6 || w == 8 || w == 9) return 32'hFFFF_FFFF;
    return 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    check("R1 irq full", {29'd0, irq_a}, 32'd0);
    check("R1 irq lite", {29'd0, irq_b}, 32'd0);

    // R1 R2 R3: sweep of word offsets in both configurations right after reset
    for (int w = 0; w < 16; w++) begin
      bus(1'b0, 12'(w * 4), 32'd0);
      check($sformatf("R3 err full w%0d", w), {31'd0, gerr_a}, {31'd0, !valid_word(1'b1, w)});
      check($sformatf("R3 err lite w%0d", w), {31'd0, gerr_b}, {31'd0, !valid_word(1'b0, w)});
      check($sformatf("R1 data full w%0d", w), got_a, valid_word(1'b1, w) ? reset_val(w) : 32'd0);
      check($sformatf("R1 data lite w%0d", w), got_b, valid_word(1'b0, w) ? reset_val(w) : 32'd0);
    end
    bus(1'b0, 12'hFFC, 32'd0);
    check("R3 top of window", {31'd0, gerr_a}, 32'd1);
    bus(1'b0, 12'h00A, 32'd0);
    check("R3 unaligned", {31'd0, gerr_a}, 32'd1);
    check("R3 unaligned data", got_a, 32'd0);

    // R2 R11 R12: readback of every writable register
    for (int w = 2; w < 12; w++) begin
      if (w != 4 && w != 7 && w != 10) bus(1'b1, 12'(w * 4), 32'hA000_0000 + 32'(w));
    end
    for (int w = 2; w < 12; w++) begin
      if (w != 4 && w != 7 && w != 10) begin
        bus(1'b0, 12'(w * 4), 32'd0);
        check($sformatf("R2 readback w%0d", w), got_a, 32'hA000_0000 + 32'(w));
      end
    end
    bus(1'b1, 12'h02C, 32'hCAFE_0001);
    bus(1'b0, 12'h02C, 32'd0);
    check("R11 capture readback", got_a, 32'hCAFE_0001);
    bus(1'b1, 12'h000, 32'h1234_56A5);
    bus(1'b0, 12'h000, 32'd0);
    check("R12 output control readback", got_a, 32'h0000_00A5);
    check("R3 output control absent", {31'd0, gerr_b}, 32'd1);
    // R3: invalid write in lite must not alias channel 0
    bus(1'b1, 12'h024, 32'h77);
    check("R3 invalid write err", {31'd0, gerr_b}, 32'd1);
    bus(1'b0, 12'h00C, 32'd0);
    check("R3 invalid write no alias", got_b, 32'hA000_0003);

    // R4 R6: channel 1 counts alone
    bus(1'b1, 12'h00C, 32'h1234);
    bus(1'b1, 12'h014, 32'd50);
    bus(1'b1, 12'h018, 32'd100);
    run_edges(3'b010, 40);
    bus(1'b0, 12'h018, 32'd0);
    check("R4 ch1 counted", got_a, 32'd60);
    bus(1'b0, 12'h00C, 32'd0);
    check("R4 ch0 held", got_a, 32'h1234);
    // R6: 10 decrements to 0, reload to 50 on the 11th, 9 more
    bus(1'b1, 12'h018, 32'd10);
    run_edges(3'b010, 20);
    bus(1'b0, 12'h018, 32'd0);
    check("R6 reload after underflow", got_a, 32'd41);
    bus(1'b0, 12'h01C, 32'd0);
    check("R6 flag set", got_a, 32'h100);
    check("R8 irq off when disabled", {29'd0, irq_a}, 32'd0);
    bus(1'b1, 12'h01C, 32'h120);
    idle(1);
    check("R8 irq ch1 on", {29'd0, irq_a}, 32'b010);
    bus(1'b0, 12'h01C, 32'd0);
    check("R9 write one keeps flag", got_a, 32'h120);
    bus(1'b1, 12'h01C, 32'h020);
    idle(1);
    check("R9 irq after clear", {29'd0, irq_a}, 32'd0);
    bus(1'b0, 12'h01C, 32'd0);
    check("R9 flag cleared", got_a, 32'h020);

    // R5: start bit for missing channel
    bus(1'b1, 12'h004, 32'd7);
    check("R5 err lite", {31'd0, gerr_b}, 32'd1);
    check("R5 no err full", {31'd0, gerr_a}, 32'd0);
    bus(1'b0, 12'h004, 32'd0);
    check("R5 start lite", got_b, 32'd3);
    check("R4 start full", got_a, 32'd7);
    bus(1'b1, 12'h004, 32'd0);

    // R7: rate sweep on channel 0, 256 counting edges each
    for (int s = 0; s < 5; s++) begin
      bus(1'b1, 12'h010, 32'(s));
      bus(1'b1, 12'h00C, 32'h1000);
      run_edges(3'b001, 256);
      bus(1'b0, 12'h00C, 32'd0);
      check($sformatf("R7 rate %0d", s), got_a, 32'h1000 - (32'd256 >> (2 * s)));
    end
    for (int s = 5; s < 8; s++) begin
      bus(1'b1, 12'h010, 32'h20 + 32'(s));
      check($sformatf("R7 reserved %0d err", s), {31'd0, gerr_a}, 32'd1);
      bus(1'b0, 12'h010, 32'd0);
      check($sformatf("R7 reserved %0d ignored", s), got_a, 32'd4);
    end
    bus(1'b1, 12'h010, 32'd0);

    // R9: underflow on the same edge as a clearing write (third channel)
    bus(1'b1, 12'h020, 32'd7);
    bus(1'b1, 12'h024, 32'd0);
    bus(1'b1, 12'h028, 32'h020);
    bus(1'b1, 12'h004, 32'd4);
    bus(1'b1, 12'h028, 32'h020);
    bus(1'b1, 12'h004, 32'd0);
    bus(1'b0, 12'h028, 32'd0);
    check("R9 underflow beats clear", got_a, 32'h120);
    bus(1'b0, 12'h024, 32'd0);
    check("R6 ch2 reload step", got_a, 32'd6);
    check("R8 irq ch2 on", {29'd0, irq_a}, 32'b100);
    check("R8 irq lite ch2 absent", {29'd0, irq_b}, 32'd0);

    // R10: count write on a tick edge wins
    bus(1'b1, 12'h00C, 32'd900);
    bus(1'b1, 12'h004, 32'd1);
    idle(3);
    bus(1'b1, 12'h00C, 32'd500);
    bus(1'b1, 12'h004, 32'd0);
    bus(1'b0, 12'h00C, 32'd0);
    check("R10 write beats tick", got_a, 32'd499);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule